// File: doc/BRIEF.md
# Global-History Correlating Branch Direction Predictor

This block predicts whether a conditional branch is taken. It keeps one global history register that is shared by all branches and holds the resolved outcomes of the most recent branches. It also keeps a table of 2-bit saturating counters. To select a counter, the block joins the low bits of the branch address with the global history. Two branches at the same address can therefore use different counters, depending on how the neighbouring branches went.

The predict side is purely combinational. A fetch stage presents an address and reads back a taken or not-taken bit in the same cycle. The update side is used when a branch resolves. It takes the branch address and its real outcome, moves the selected counter one step toward that outcome, and shifts the outcome into the history.

Counters carry no tag, so unrelated branches that map to the same index share a counter. Target prediction and repair of speculative history are not part of this block.

Top module: `gpred_top`

## Requirements
- R1: After reset the history is all zeros and every counter holds 1, so every address predicts not-taken.
- R2: The counter index is the concatenation {PC[PC_BITS-1:0], history}, with the address bits as the upper part and history bit 0 as the index LSB.
- R3: An update with outcome taken adds one to the selected counter, and a counter already at 3 stays at 3.
- R4: An update with outcome not-taken subtracts one from the selected counter, and a counter already at 0 stays at 0.
- R5: The prediction is taken (1) exactly when the selected counter is 2 or 3.
- R6: An update changes only the counter selected by its own address and the history, and leaves every other counter unchanged.
- R7: On update, the outcome enters history bit 0, every other bit moves up by one, and the oldest bit is dropped. The update selects its counter with the history from before this shift.
- R8: When a predict and an update occur in the same cycle, the prediction reflects the state from before that update.
- R9: Address bits at or above PC_BITS have no effect on which counter is selected, for both predict and update.
- R10: While upd_en is low, the update inputs are ignored, and the counters and history keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_pc | input | ADDR_W | Address of the branch being predicted |
| pred_taken | output | 1 | Combinational prediction, 1 = taken |
| upd_en | input | 1 | Resolved-branch update strobe |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench builds the block with a 12-bit address, 3 address bits and 3 history bits, which gives a 64-entry table. With a table this small, a few hundred pseudo-random updates drive counters into both saturation limits. The same setup makes every history value recur often, so addresses that alias on the same index get exercised repeatedly. Since the history is only three bits deep, a handful of updates with the same outcome pins it to a known value, and directed runs can then hammer a single counter on purpose.

// File: rtl/gpred_pkg.sv
package gpred_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_RESET = 2'd1;
    localparam ctr_t CTR_MAX   = 2'd3;
    localparam ctr_t CTR_MIN   = 2'd0;

    typedef struct packed {
        logic valid;
        logic taken;
    } outcome_t;

    function automatic ctr_t ctr_train(input ctr_t cur, input logic taken);
        ctr_t nxt;
        if (taken) begin
            nxt = (cur == CTR_MAX) ? cur : cur + 2'd1;
        end else begin
            nxt = (cur == CTR_MIN) ? cur : cur - 2'd1;
        end
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(input ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/gpred_idx.sv
module gpred_idx #(
    parameter int ADDR_W    = 32,
    parameter int PC_BITS   = 6,
    parameter int HIST_BITS = 4,
    localparam int IDX_W    = PC_BITS + HIST_BITS
) (
    input  logic [ADDR_W-1:0]    pc,
    input  logic [HIST_BITS-1:0] hist,
    output logic [IDX_W-1:0]     idx
);
    always_comb begin
        idx = {pc[PC_BITS-1:0], hist};
    end
endmodule

// File: rtl/gpred_hist.sv
module gpred_hist
    import gpred_pkg::*;
#(
    parameter int HIST_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  outcome_t             res,
    output logic [HIST_BITS-1:0] hist
);
    logic [HIST_BITS-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (res.valid) begin
            hist_q <= {hist_q[HIST_BITS-2:0], res.taken};
        end
    end

    assign hist = hist_q;

    // R7
    shift_in_chk: assert property (@(posedge clk) disable iff (rst)
        res.valid |=> (hist_q[0] == $past(res.taken)) &&
                      (hist_q[HIST_BITS-1:1] == $past(hist_q[HIST_BITS-2:0])));

    // R10
    hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !res.valid |=> $stable(hist_q));
endmodule

// File: rtl/gpred_table.sv
module gpred_table
    import gpred_pkg::*;
#(
    parameter int IDX_W = 10,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    ctr_t [DEPTH-1:0] cnt_q;
    ctr_t             wr_cur;

    assign wr_cur = cnt_q[wr_idx];
    assign rd_ctr = cnt_q[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= {DEPTH{CTR_RESET}};
        end else if (wr_en) begin
            cnt_q[wr_idx] <= ctr_train(wr_cur, wr_taken);
        end
    end

    // R3
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken && wr_cur != CTR_MAX) |=>
        cnt_q[$past(wr_idx)] == $past(wr_cur) + 2'd1);

    // R3
    ceiling_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken && wr_cur == CTR_MAX) |=>
        cnt_q[$past(wr_idx)] == CTR_MAX);

    // R4
    floor_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken && wr_cur == CTR_MIN) |=>
        cnt_q[$past(wr_idx)] == CTR_MIN);

    // R10
    table_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cnt_q));
endmodule

// File: rtl/gpred_top.sv
module gpred_top
    import gpred_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PC_BITS   = 6,
    parameter int HIST_BITS = 4,
    localparam int IDX_W    = PC_BITS + HIST_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] pred_pc,
    output logic              pred_taken,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken
);
    logic [HIST_BITS-1:0] hist;
    logic [IDX_W-1:0]     pred_idx;
    logic [IDX_W-1:0]     upd_idx;
    ctr_t                 pred_ctr;
    outcome_t             res;

    assign res.valid = upd_en;
    assign res.taken = upd_taken;

    gpred_hist #(.HIST_BITS(HIST_BITS)) u_hist (
        .clk (clk),
        .rst (rst),
        .res (res),
        .hist(hist)
    );

    gpred_idx #(.ADDR_W(ADDR_W), .PC_BITS(PC_BITS), .HIST_BITS(HIST_BITS)) u_pidx (
        .pc  (pred_pc),
        .hist(hist),
        .idx (pred_idx)
    );

    gpred_idx #(.ADDR_W(ADDR_W), .PC_BITS(PC_BITS), .HIST_BITS(HIST_BITS)) u_uidx (
        .pc  (upd_pc),
        .hist(hist),
        .idx (upd_idx)
    );

    gpred_table #(.IDX_W(IDX_W)) u_tab (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (pred_idx),
        .rd_ctr  (pred_ctr),
        .wr_en   (upd_en),
        .wr_idx  (upd_idx),
        .wr_taken(upd_taken)
    );

    assign pred_taken = ctr_says_taken(pred_ctr);
endmodule

// File: tb/gpred_top_test.sv
module gpred_top_test;
    localparam int AW = 12;
    localparam int PB = 3;
    localparam int HB = 3;
    localparam int DEPTH = 1 << (PB + HB);

    logic clk = 1'b0;
    logic rst;
    logic [AW-1:0] pred_pc;
    logic pred_taken;
    logic upd_en;
    logic [AW-1:0] upd_pc;
    logic upd_taken;

    always #10 clk = ~clk;

    gpred_top #(.ADDR_W(AW), .PC_BITS(PB), .HIST_BITS(HB)) uut (
        .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .upd_en(upd_en), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    typedef struct {
        bit    exp;
        string tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    int mctr[DEPTH];
    int mhist = 0;
    bit done = 0;

    task automatic step(input logic [AW-1:0] pp, input bit ue,
                        input logic [AW-1:0] up, input bit ut, input string tag);
        item_t it;
        int pi, ui;
        @(negedge clk);
        pred_pc = pp; upd_en = ue; upd_pc = up; upd_taken = ut;
        pi = ((int'(pp) & ((1 << PB) - 1)) << HB) | mhist;
        it.exp = (mctr[pi] >= 2);
        it.tag = tag;
        q.push_back(it);
        if (ue) begin
            ui = ((int'(up) & ((1 << PB) - 1)) << HB) | mhist;
            if (ut) mctr[ui] = (mctr[ui] == 3) ? 3 : mctr[ui] + 1;
            else    mctr[ui] = (mctr[ui] == 0) ? 0 : mctr[ui] - 1;
            mhist = ((mhist << 1) | int'(ut)) & ((1 << HB) - 1);
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (pred_taken !== it.exp) begin
                    errors++;
                    $display("FAIL %s pc=%0h actual=%0b expected=%0b",
                             it.tag, pred_pc, pred_taken, it.exp);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        rst = 1'b1; upd_en = 0; upd_pc = '0; upd_taken = 0; pred_pc = '0;
        foreach (mctr[i]) mctr[i] = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state over every address slot
        for (int a = 0; a < (1 << PB); a++) step(AW'(a), 0, '0, 0, "R1 reset");
        // R3 R5 drive history to all-taken, then saturate one counter
        for (int k = 0; k < 8; k++) step(AW'(5), 1, AW'(5), 1, "R3 R5 R8 climb");
        step(AW'(5), 0, '0, 0, "R3 R5 saturated");
        // R9 upper address bits alias onto the same counter
        step(AW'(5 + (7 << PB)), 0, '0, 0, "R9 alias predict");
        step(AW'(5 + (3 << PB)), 1, AW'(5 + (9 << PB)), 0, "R9 alias update");
        // R6 neighbours untouched
        for (int a = 0; a < (1 << PB); a++) step(AW'(a), 0, '0, 0, "R6 R2 others");
        // R4 drain to zero at history 000, then one taken step
        for (int k = 0; k < 8; k++) step(AW'(2), 1, AW'(2), 0, "R4 R7 descend");
        step(AW'(2), 1, AW'(2), 1, "R4 floor+1");
        step(AW'(2), 0, '0, 0, "R4 R7 post-floor");
        // R10 disabled update inputs wiggle
        for (int k = 0; k < 6; k++) step(AW'(k), 0, AW'(k * 3), k[0], "R10 ignored");
        // R2 R6 R7 R8 pseudo-random mix
        lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(AW'(lfsr[11:0]), lfsr[3] | lfsr[7], AW'({lfsr[5:0], lfsr[15:10]}),
                 lfsr[2] ^ lfsr[9], "R2 R6 R7 R8 mix");
        end
        upd_en = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule